// File: doc/BRIEF.md
# Transmit Jitter Attenuator Elastic Buffer

This block is the elastic store of a transmit jitter attenuator. A serial bit stream arrives with jitter on a write clock and is written one bit per enabled cycle. A separately generated smoothed clock drains it, one bit per enabled read. That clock comes from outside the block. The usable depth can be switched at run time between a quarter, a half and the whole of the physical storage. With the default sizing these are 32, 64 and 128 bits. After reset, after a depth change and after any slip, the read side places its pointer half the selected depth behind the write pointer. Every bit then sees the same delay.

All status sits in the read-clock domain. The write pointer crosses into that domain in Gray code through a two-flop synchronizer. The block reports a slip (overflow or underflow) in a sticky flag that drives a maskable interrupt. When the limit function is on, it asks the clock generator to speed up or slow down as the fill level nears either end. It also reports the spacing between the write and read pointers as a 7-bit field. The field shows either the live spacing or the largest value seen so far.

Top module: `tx_jitter_fifo`

## Requirements
- R1: `depth_sel` selects the active depth D. 2'b00 gives MAX_DEPTH/4, 2'b01 gives MAX_DEPTH/2, and 2'b10 or 2'b11 gives MAX_DEPTH. Any change of `depth_sel` makes the new depth active and re-centres the buffer.
- R2: After reset, after a depth change or after a slip, the read pointer sits exactly D/2 bits behind the write pointer. A bit written into an otherwise idle buffer therefore comes out on the (D/2+1)-th later read.
- R3: Bits come out on `rd_bit` in the order in which they were written. `rd_bit` is registered and changes on the read-clock edge that performs the read.
- R4: The fill level is the synchronized write pointer minus the read pointer. When it exceeds D, an overflow is detected: `xrun_sticky` is set and the buffer re-centres to D/2.
- R5: A read requested while the fill level is zero is an underflow. `rd_bit` keeps its previous value, the read pointer does not advance, `xrun_sticky` is set and the buffer re-centres to D/2.
- R6: `xrun_sticky` stays set until a cycle with `stat_clr` high, and it clears only then. `irq` is high exactly when `xrun_sticky` is high and `irq_en` is high.
- R7: When `limit_en` is high, `speed_up` is high while fill > D-4 and `slow_down` is high while fill < 4. When `limit_en` is low, both are low.
- R8: When `peak_mode` is low, `interval` shows the fill level modulo D.
- R9: When `peak_mode` is high, `interval` holds the largest value of (fill modulo D) seen since peak mode was entered, counting the live value at entry.
- R10: While `wr_rst` and `rd_rst` are high, `rd_bit`, `xrun_sticky`, `irq`, `speed_up`, `slow_down` and `interval` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Jittered input-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write one bit this cycle |
| wr_bit | input | 1 | Incoming data bit |
| rd_clk | input | 1 | Smoothed output-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read one bit this cycle |
| depth_sel | input | 2 | Active depth select |
| limit_en | input | 1 | Enable rate-steering requests |
| irq_en | input | 1 | Interrupt enable |
| peak_mode | input | 1 | 1 selects peak hold of the pointer interval, 0 selects live |
| stat_clr | input | 1 | Clears the sticky slip flag |
| rd_bit | output | 1 | Outgoing data bit |
| xrun_sticky | output | 1 | Sticky overflow/underflow flag |
| irq | output | 1 | Masked interrupt |
| speed_up | output | 1 | Request a faster read clock |
| slow_down | output | 1 | Request a slower read clock |
| interval | output | 7 | Pointer interval, live or peak |

## Verification
The bench builds the block with its default MAX_DEPTH of 128, so all three depth settings can be reached from the port. Overflow is reachable at 33, 65 and 129 bits of fill, and the modulo fold of the interval field wraps at each of the three depths. Both clocks run at the same period with a fixed phase offset. Every pointer value is then seen for a full read cycle, which makes the peak-hold result and the limit thresholds predictable once the synchronizer has settled.

// File: rtl/jaf_pkg.sv
package jaf_pkg;

  typedef enum logic [1:0] {
    DSEL_QUARTER = 2'b00,
    DSEL_HALF    = 2'b01,
    DSEL_FULL    = 2'b10,
    DSEL_FULL_B  = 2'b11
  } depth_sel_e;

  // Active depth for a select code, given the physical storage size.
  function automatic int unsigned depth_of(input logic [1:0] sel,
                                           input int unsigned max_depth);
    case (depth_sel_e'(sel))
      DSEL_QUARTER: return max_depth / 4;
      DSEL_HALF:    return max_depth / 2;
      default:      return max_depth;
    endcase
  endfunction

endpackage

// File: rtl/jaf_sync.sv
module jaf_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/jaf_wr_ptr.sv
module jaf_wr_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_en,
  output logic [PTR_W-1:0] wbin,
  output logic [PTR_W-1:0] wgray
);
  logic [PTR_W-1:0] wbin_nxt;

  assign wbin_nxt = wbin + PTR_W'(1);

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en) begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end
endmodule

// File: rtl/jaf_mem.sv
module jaf_mem #(
  parameter int AW = 7
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  localparam int ENTRIES = 1 << AW;

  logic store [ENTRIES];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)  rdata <= 1'b0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/jaf_rd_ctrl.sv
module jaf_rd_ctrl
  import jaf_pkg::*;
#(
  parameter int MAX_DEPTH = 128,
  parameter int PTR_W     = 8,
  parameter int AW        = 7
) (
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             rd_en,
  input  logic [1:0]       depth_sel,
  input  logic [PTR_W-1:0] wgray_s,
  output logic [AW-1:0]    raddr,
  output logic             re,
  output logic [PTR_W-1:0] fill,
  output logic [PTR_W-1:0] depth,
  output logic             ovf,
  output logic             udf
);
  logic [PTR_W-1:0] rptr;
  logic [PTR_W-1:0] wbin_s;
  logic [PTR_W-1:0] depth_new;
  logic [1:0]       depth_q;
  logic             cen_pend;
  logic             sel_chg;
  logic             recentre;

  // Gray to binary: each bit is the parity of the Gray bits at and above it.
  always_comb begin
    for (int i = 0; i < PTR_W; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign depth     = PTR_W'(depth_of(depth_q, MAX_DEPTH));
  assign depth_new = PTR_W'(depth_of(depth_sel, MAX_DEPTH));
  assign fill      = wbin_s - rptr;
  assign sel_chg   = depth_sel != depth_q;
  assign ovf       = !cen_pend && (fill > depth);
  assign udf       = !cen_pend && rd_en && (fill == '0);
  assign recentre  = cen_pend || ovf || udf || sel_chg;
  assign re        = rd_en && !recentre;
  assign raddr     = rptr[AW-1:0];

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rptr     <= '0;
      cen_pend <= 1'b1;
      depth_q  <= depth_sel;
    end else if (recentre) begin
      rptr     <= wbin_s - (depth_new >> 1);
      cen_pend <= 1'b0;
      depth_q  <= depth_sel;
    end else if (rd_en) begin
      rptr <= rptr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/jaf_monitor.sv
module jaf_monitor #(
  parameter int PTR_W  = 8,
  parameter int IVW    = 7,
  parameter int MARGIN = 4
) (
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic [PTR_W-1:0] fill,
  input  logic [PTR_W-1:0] depth,
  input  logic             ovf,
  input  logic             udf,
  input  logic             stat_clr,
  input  logic             irq_en,
  input  logic             limit_en,
  input  logic             peak_mode,
  output logic             xrun_sticky,
  output logic             irq,
  output logic             speed_up,
  output logic             slow_down,
  output logic [IVW-1:0]   interval
);
  logic             sticky_nxt;
  logic [PTR_W-1:0] folded;
  logic [IVW-1:0]   cur_iv;

  assign sticky_nxt = ovf || udf || (xrun_sticky && !stat_clr);
  assign folded     = fill & (depth - PTR_W'(1));
  assign cur_iv     = folded[IVW-1:0];

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      xrun_sticky <= 1'b0;
      irq         <= 1'b0;
      speed_up    <= 1'b0;
      slow_down   <= 1'b0;
      interval    <= '0;
    end else begin
      xrun_sticky <= sticky_nxt;
      irq         <= sticky_nxt && irq_en;
      speed_up    <= limit_en && (fill > (depth - PTR_W'(MARGIN)));
      slow_down   <= limit_en && (fill < PTR_W'(MARGIN));
      if (peak_mode) interval <= (cur_iv > interval) ? cur_iv : interval;
      else           interval <= cur_iv;
    end
  end
endmodule

// File: rtl/tx_jitter_fifo.sv
module tx_jitter_fifo #(
  parameter int MAX_DEPTH = 128,
  parameter int MARGIN    = 4
) (
  input  logic       wr_clk,
  input  logic       wr_rst,
  input  logic       wr_en,
  input  logic       wr_bit,
  input  logic       rd_clk,
  input  logic       rd_rst,
  input  logic       rd_en,
  input  logic [1:0] depth_sel,
  input  logic       limit_en,
  input  logic       irq_en,
  input  logic       peak_mode,
  input  logic       stat_clr,
  output logic       rd_bit,
  output logic       xrun_sticky,
  output logic       irq,
  output logic       speed_up,
  output logic       slow_down,
  output logic [6:0] interval
);
  localparam int AW    = $clog2(MAX_DEPTH);
  localparam int PTR_W = AW + 1;

  logic [PTR_W-1:0] wbin, wgray, wgray_s, fill, depth;
  logic [AW-1:0]    raddr;
  logic             re, ovf, udf;

  jaf_wr_ptr #(.PTR_W(PTR_W)) u_wr (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en),
    .wbin(wbin), .wgray(wgray)
  );

  jaf_sync #(.W(PTR_W)) u_sync (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );

  jaf_mem #(.AW(AW)) u_mem (
    .wr_clk(wr_clk), .we(wr_en), .waddr(wbin[AW-1:0]), .wdata(wr_bit),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .re(re), .raddr(raddr), .rdata(rd_bit)
  );

  jaf_rd_ctrl #(.MAX_DEPTH(MAX_DEPTH), .PTR_W(PTR_W), .AW(AW)) u_rd (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .depth_sel(depth_sel),
    .wgray_s(wgray_s), .raddr(raddr), .re(re), .fill(fill), .depth(depth),
    .ovf(ovf), .udf(udf)
  );

  jaf_monitor #(.PTR_W(PTR_W), .IVW(7), .MARGIN(MARGIN)) u_mon (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .fill(fill), .depth(depth),
    .ovf(ovf), .udf(udf), .stat_clr(stat_clr), .irq_en(irq_en),
    .limit_en(limit_en), .peak_mode(peak_mode), .xrun_sticky(xrun_sticky),
    .irq(irq), .speed_up(speed_up), .slow_down(slow_down), .interval(interval)
  );
endmodule

// File: rtl/jaf_chk.sv
module jaf_chk (
  input logic       rd_clk,
  input logic       rd_rst,
  input logic       limit_en,
  input logic       peak_mode,
  input logic       stat_clr,
  input logic       xrun_sticky,
  input logic       irq,
  input logic       speed_up,
  input logic       slow_down,
  input logic [6:0] interval
);
  AST_IRQ_NEEDS_STICKY: assert property (@(posedge rd_clk) disable iff (rd_rst)
    irq |-> xrun_sticky); // R6

  AST_STICKY_HOLDS: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (xrun_sticky && !stat_clr) |=> xrun_sticky); // R6

  AST_STEER_EXCLUSIVE: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(speed_up && slow_down)); // R7

  AST_STEER_OFF: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !$past(limit_en) |-> (!speed_up && !slow_down)); // R7

  AST_PEAK_NO_DROP: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (peak_mode && $past(peak_mode)) |-> (interval >= $past(interval))); // R9
endmodule

bind tx_jitter_fifo jaf_chk u_chk (
  .rd_clk(rd_clk), .rd_rst(rd_rst), .limit_en(limit_en),
  .peak_mode(peak_mode), .stat_clr(stat_clr), .xrun_sticky(xrun_sticky),
  .irq(irq), .speed_up(speed_up), .slow_down(slow_down), .interval(interval)
);

// File: tb/tx_jitter_fifo_tb.sv
module tx_jitter_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXD = 128;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst = 1, rd_rst = 1, wr_en = 0, wr_bit = 0, rd_en = 0;
  logic [1:0] depth_sel = 2'b00;
  logic limit_en = 1, irq_en = 1, peak_mode = 0, stat_clr = 0;
  logic rd_bit, xrun_sticky, irq, speed_up, slow_down;
  logic [6:0] interval;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] bwp, brp;
  bit mem_m [MAXD];
  bit known_m [MAXD];
  int dm, peak_m;
  bit sticky_m, pk_m;
  logic [1:0] sel_m;

  tx_jitter_fifo u_dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_bit(wr_bit),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .depth_sel(depth_sel),
    .limit_en(limit_en), .irq_en(irq_en), .peak_mode(peak_mode),
    .stat_clr(stat_clr), .rd_bit(rd_bit), .xrun_sticky(xrun_sticky),
    .irq(irq), .speed_up(speed_up), .slow_down(slow_down), .interval(interval)
  );

  initial forever #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial begin #3; forever #(CLK_PERIOD/2) rd_clk = ~rd_clk; end

  function automatic int dec_depth(input logic [1:0] s);
    return (s == 2'b00) ? MAXD/4 : (s == 2'b01) ? MAXD/2 : MAXD;
  endfunction
  function automatic int fill_f();
    logic [7:0] d;
    d = bwp - brp;
    return int'(d);
  endfunction
  function automatic bit exp_speed(input int f);
    return limit_en && (f > dm - 4);
  endfunction
  function automatic bit exp_slow(input int f);
    return limit_en && (f < 4);
  endfunction
  function automatic int exp_interval(input int f);
    return pk_m ? peak_m : (f % dm);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic note_visit();
    if (pk_m && (fill_f() % dm) > peak_m) peak_m = fill_f() % dm;
  endtask

  task automatic recentre();
    brp = bwp - 8'(dm / 2);
    note_visit();
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic check_state();
    int f;
    f = fill_f();
    chk(xrun_sticky == sticky_m, "R6 sticky", xrun_sticky, sticky_m);
    chk(irq == (sticky_m && irq_en), "R6 irq", irq, sticky_m && irq_en);
    chk(speed_up == exp_speed(f), "R7 speed_up", speed_up, exp_speed(f));
    chk(slow_down == exp_slow(f), "R7 slow_down", slow_down, exp_slow(f));
    chk(int'(interval) == exp_interval(f), pk_m ? "R9 peak interval" : "R8 live interval",
        interval, exp_interval(f));
  endtask

  task automatic do_reset();
    wr_rst = 1; rd_rst = 1;
    repeat (3) @(negedge rd_clk);
    chk(rd_bit == 0, "R10 rd_bit", rd_bit, 0);
    chk(xrun_sticky == 0, "R10 sticky", xrun_sticky, 0);
    chk(irq == 0, "R10 irq", irq, 0);
    chk(speed_up == 0 && slow_down == 0, "R10 steer", {speed_up, slow_down}, 0);
    chk(interval == 0, "R10 interval", interval, 0);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    sel_m = depth_sel; dm = dec_depth(depth_sel);
    bwp = 0; brp = 0; sticky_m = 0; peak_m = 0; pk_m = peak_mode;
    recentre();
    settle();
  endtask

  task automatic wr_burst(input int k);
    for (int i = 0; i < k; i++) begin
      bit b;
      @(negedge wr_clk);
      b = 1'($urandom);
      wr_en = 1; wr_bit = b;
      mem_m[bwp[6:0]] = b; known_m[bwp[6:0]] = 1;
      bwp = bwp + 8'd1;
      note_visit();
      if (fill_f() > dm) begin sticky_m = 1; recentre(); end
    end
    @(negedge wr_clk); wr_en = 0;
    settle();
  endtask

  task automatic rd_burst(input int m, input string req);
    bit ev = 0, eb = 0, cur;
    string er = req;
    for (int i = 0; i < m; i++) begin
      @(negedge rd_clk);
      cur = rd_bit;
      if (ev) chk(cur == eb, er, cur, eb);
      rd_en = 1;
      if (fill_f() == 0) begin
        sticky_m = 1; ev = 1; eb = cur; er = "R5 hold on underflow";
        recentre();
      end else begin
        ev = known_m[brp[6:0]]; eb = mem_m[brp[6:0]]; er = req;
        brp = brp + 8'd1;
        note_visit();
      end
    end
    @(negedge rd_clk);
    cur = rd_bit;
    if (m > 0 && ev) chk(cur == eb, er, cur, eb);
    rd_en = 0;
    settle();
  endtask

  task automatic set_depth(input logic [1:0] s);
    @(negedge rd_clk);
    depth_sel = s;
    if (s != sel_m) begin
      sel_m = s; dm = dec_depth(s); recentre();
    end
    settle();
  endtask

  task automatic set_peak(input bit v);
    @(negedge rd_clk);
    peak_mode = v;
    if (v && !pk_m) peak_m = fill_f() % dm;
    pk_m = v;
    settle();
  endtask

  task automatic clear_status();
    @(negedge rd_clk); stat_clr = 1;
    @(negedge rd_clk); stat_clr = 0;
    sticky_m = 0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MAXD; i++) known_m[i] = 0;
    do_reset();
    // R2: centred to half of 32 after reset
    chk(int'(interval) == 16, "R2 centre after reset", interval, 16);
    check_state();
    // fill to exactly D: speed-up, interval folds to 0 (R8)
    wr_burst(16);
    chk(speed_up == 1, "R7 near full", speed_up, 1);
    check_state();
    // drain: 16 stale bits then written data in order (R2 delay, R3)
    rd_burst(32, "R2 delay and R3 order");
    chk(slow_down == 1, "R7 near empty", slow_down, 1);
    check_state();
    rd_burst(1, "R5");
    chk(xrun_sticky == 1, "R5 underflow sets sticky", xrun_sticky, 1);
    check_state();
    clear_status();
    check_state();
    // overflow with interrupt masked (R4)
    irq_en = 0;
    wr_burst(17);
    chk(xrun_sticky == 1 && irq == 0, "R4 overflow masked irq", {xrun_sticky, irq}, 2);
    check_state();
    irq_en = 1; settle();
    check_state();
    clear_status();
    // depth changes (R1)
    set_depth(2'b01);
    chk(int'(interval) == 32, "R1 depth 64 centre", interval, 32);
    set_depth(2'b10);
    chk(int'(interval) == 64, "R1 depth 128 centre", interval, 64);
    set_depth(2'b11);
    check_state();
    limit_en = 0;
    wr_burst(62);
    check_state();
    limit_en = 1; settle();
    check_state();
    set_peak(1);
    rd_burst(40, "R3");
    check_state();
    wr_burst(20);
    check_state();
    set_peak(0);
    check_state();
    for (int it = 0; it < 150; it++) begin
      int f;
      f = fill_f();
      case ($urandom_range(0, 5))
        0: wr_burst($urandom_range(0, dm + 1 - f));
        1: rd_burst($urandom_range(0, f + 1), "R3");
        2: if (!pk_m) set_depth(2'($urandom_range(0, 3)));
        3: set_peak(1'($urandom));
        4: clear_status();
        default: begin
          limit_en = 1'($urandom); irq_en = 1'($urandom); settle();
        end
      endcase
      check_state();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule